// File: doc/BRIEF.md
# Interrupt Controller Register Decoder

This block sits between a simple 32-bit valid/ready register port and the storage and arbitration core of a platform interrupt controller. It turns each word address into one of four windows: source priorities, pending bits, per-context enable words and per-context threshold/claim registers. For writes it raises a one-cycle strobe to the core with the decoded index and data. For reads it selects the value the core exposes and returns it with the acknowledge. A read of a context's claim register is not a plain read: it raises a claim strobe, and the core answers with the identifier it has just claimed.

Source 0 means "no interrupt", so the first priority word belongs to source 1. Each context owns a power-of-two block in the enable window and another in the threshold window. The context number is taken by shifting the offset. Window bases, strides, the source count, the context count, the priority width and the highest legal priority are parameters. Every access is acknowledged one cycle after it is accepted. An access that decodes to nothing returns zero and flags an error.

Top module: `intc_reg_decoder`

## Requirements
- R1: A request is accepted in a cycle where `req_valid` is high and `req_ready` is low. `req_ready` is then high for exactly one cycle, the next one, and `resp_rdata`/`resp_err` are valid in that cycle.
- R2: An address with bits [1:0] not zero is an error. A read returns 0 and no strobe is raised.
- R3: Priority word n (address PRIO_BASE+4n, n < NSRC) belongs to source n+1. A read returns that source's priority. A write raises `prio_we` with `core_src` = n+1 and `prio_val` = the low PRIO_W bits of the write data.
- R4: The pending window holds ceil((NSRC+1)/32) words, where bit b of word w is identifier 32w+b. A read returns that word. A write is an error and raises no strobe.
- R5: In the enable window the context is (offset >> log2 EN_STRIDE) and the word is bits of the offset inside the stride, shifted right by 2. A word below the pending word count reads or writes `en_we` with `core_ctx`, `core_word` and `core_wdata`. A higher word is an error.
- R6: Offset 0 of a threshold block reads the context threshold. A write raises `thr_we` only when the full 32-bit data is at most MAX_PRIO. A larger value is dropped without strobe and without error.
- R7: A read of offset 4 of a threshold block raises `claim_stb` for that context in the accept cycle and returns `claim_id`.
- R8: A write of offset 4 raises `cmpl_stb` with `core_ctx` = the context and `core_src` = the low ID bits of the data.
- R9: Any other offset inside a threshold block is an error.
- R10: An address outside all four windows is an error. A read returns 0 and no strobe is raised. Every error response carries read data 0.
- R11: `claim_stb` fires exactly once per read transaction, even when `req_valid` stays high across back-to-back transactions.
- R12: At most one of the five core strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Acknowledge, one cycle per transaction |
| resp_rdata | output | 32 | Read data, valid with `req_ready` |
| resp_err | output | 1 | Error flag, valid with `req_ready` |
| prio_we | output | 1 | Priority write strobe |
| en_we | output | 1 | Enable word write strobe |
| thr_we | output | 1 | Threshold write strobe |
| claim_stb | output | 1 | Claim request |
| cmpl_stb | output | 1 | Completion notice |
| core_src | output | ID_W | Source for priority writes, identifier for completion |
| core_ctx | output | CTX_W | Context index |
| core_word | output | WD_W | Enable word index |
| core_wdata | output | 32 | Raw write data (enable words) |
| prio_val | output | PRIO_W | Priority value to store |
| thr_val | output | PRIO_W | Threshold value to store |
| prio_rd | input | NSRC*PRIO_W | Priorities, entry i = source i+1 |
| pend_rd | input | NWORDS*32 | Pending words |
| en_rd | input | NCTX*NWORDS*32 | Enable words, context-major |
| thr_rd | input | NCTX*PRIO_W | Thresholds |
| claim_id | input | ID_W | Identifier claimed by the core in answer to `claim_stb` |

## Verification
The hardest case to reach is a claim read made while the bus never drops `req_valid`. A second transaction starts in the cycle right after the acknowledge, so a decoder that raised its strobe from the level of the request rather than from the accept would claim twice. The stimulus chains two claim reads with no idle cycle between them. It also places accesses just past the end of each window and in the unused words inside an enable stride, where a decoder that only checks window bounds would accept them.

// File: rtl/intc_dec_pkg.sv
// Shared types for the interrupt controller register decoder.
package intc_dec_pkg;
    // Decoded register class of one access.
    typedef enum logic [2:0] {
        RG_BAD   = 3'd0,
        RG_PRIO  = 3'd1,
        RG_PEND  = 3'd2,
        RG_EN    = 3'd3,
        RG_THR   = 3'd4,
        RG_CLAIM = 3'd5
    } rg_kind_t;
endpackage

// File: rtl/intc_addr_decode.sv
// Address decoder: classifies a byte address into a register class and
// extracts the source/context index and the enable word index.
// Assumes strides are powers of two and windows do not overlap.
module intc_addr_decode
    import intc_dec_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          NSRC       = 40,
    parameter int          NCTX       = 2,
    parameter logic [31:0] PRIO_BASE  = 32'h0000,
    parameter logic [31:0] PEND_BASE  = 32'h1000,
    parameter logic [31:0] EN_BASE    = 32'h2000,
    parameter logic [31:0] EN_STRIDE  = 32'h0080,
    parameter logic [31:0] CTX_BASE   = 32'h4000,
    parameter logic [31:0] CTX_STRIDE = 32'h1000,
    parameter int          IDX_W      = 6,
    parameter int          WD_W       = 1
) (
    input  logic [ADDR_W-1:0] addr,
    output rg_kind_t          kind,
    output logic [IDX_W-1:0]  idx,
    output logic [WD_W-1:0]   word
);
    localparam int          NWORDS    = (NSRC + 1 + 31) / 32;
    localparam int          EN_SH     = $clog2(EN_STRIDE);
    localparam int          CTX_SH    = $clog2(CTX_STRIDE);
    localparam logic [31:0] PRIO_SPAN = 32'(NSRC * 4);
    localparam logic [31:0] PEND_SPAN = 32'(NWORDS * 4);
    localparam logic [31:0] EN_SPAN   = 32'(NCTX) * EN_STRIDE;
    localparam logic [31:0] CTX_SPAN  = 32'(NCTX) * CTX_STRIDE;

    logic [31:0] a32, p_off, q_off, e_off, c_off, e_word, c_inner;

    assign a32     = 32'(addr);
    assign p_off   = a32 - PRIO_BASE;
    assign q_off   = a32 - PEND_BASE;
    assign e_off   = a32 - EN_BASE;
    assign c_off   = a32 - CTX_BASE;
    assign e_word  = (e_off & (EN_STRIDE - 32'd1)) >> 2;
    assign c_inner = c_off & (CTX_STRIDE - 32'd1);

    // Window selection; offsets wrap below a base so one compare suffices.
    always_comb begin
        kind = RG_BAD;
        idx  = '0;
        word = '0;
        if (a32[1:0] != 2'b00) begin
            kind = RG_BAD;
        end else if (p_off < PRIO_SPAN) begin
            kind = RG_PRIO;
            idx  = IDX_W'(p_off >> 2) + IDX_W'(1);
        end else if (q_off < PEND_SPAN) begin
            kind = RG_PEND;
            word = WD_W'(q_off >> 2);
        end else if (e_off < EN_SPAN) begin
            idx  = IDX_W'(e_off >> EN_SH);
            word = WD_W'(e_word);
            if (e_word < 32'(NWORDS)) kind = RG_EN;
        end else if (c_off < CTX_SPAN) begin
            idx = IDX_W'(c_off >> CTX_SH);
            if (c_inner == 32'd0)      kind = RG_THR;
            else if (c_inner == 32'd4) kind = RG_CLAIM;
        end
    end
endmodule

// File: rtl/intc_strobe_gen.sv
// Strobe generator: turns an accepted, decoded access into core strobes
// and the error flag. Assumes 'fire' is high for one cycle per transaction.
module intc_strobe_gen
    import intc_dec_pkg::*;
#(
    parameter int ID_W     = 6,
    parameter int CTX_W    = 1,
    parameter int IDX_W    = 6,
    parameter int PRIO_W   = 3,
    parameter int MAX_PRIO = 5
) (
    input  logic              fire,
    input  logic              write,
    input  logic [31:0]       wdata,
    input  rg_kind_t          kind,
    input  logic [IDX_W-1:0]  idx,
    output logic              acc_err,
    output logic              prio_we,
    output logic              en_we,
    output logic              thr_we,
    output logic              claim_stb,
    output logic              cmpl_stb,
    output logic [ID_W-1:0]   core_src,
    output logic [CTX_W-1:0]  core_ctx,
    output logic [PRIO_W-1:0] prio_val,
    output logic [PRIO_W-1:0] thr_val
);
    logic thr_ok;

    // Threshold acceptance uses the whole data word.
    assign thr_ok = (wdata <= 32'(MAX_PRIO));

    // Error: undecoded address or a write into the read-only pending window.
    assign acc_err = (kind == RG_BAD) || (write && (kind == RG_PEND));

    // One strobe per class, only in the accept cycle.
    assign prio_we   = fire && write  && (kind == RG_PRIO);
    assign en_we     = fire && write  && (kind == RG_EN);
    assign thr_we    = fire && write  && (kind == RG_THR) && thr_ok;
    assign claim_stb = fire && !write && (kind == RG_CLAIM);
    assign cmpl_stb  = fire && write  && (kind == RG_CLAIM);

    // Index and value fields for the core.
    assign core_src = (kind == RG_CLAIM) ? wdata[ID_W-1:0] : ID_W'(idx);
    assign core_ctx = CTX_W'(idx);
    assign prio_val = wdata[PRIO_W-1:0];
    assign thr_val  = wdata[PRIO_W-1:0];
endmodule

// File: rtl/intc_rdata_mux.sv
// Read data selector: picks the core-held value for a decoded read.
// Assumes the decoder only produces in-range indices for valid classes.
module intc_rdata_mux
    import intc_dec_pkg::*;
#(
    parameter int NSRC   = 40,
    parameter int NCTX   = 2,
    parameter int NWORDS = 2,
    parameter int PRIO_W = 3,
    parameter int ID_W   = 6,
    parameter int IDX_W  = 6,
    parameter int WD_W   = 1
) (
    input  rg_kind_t                   kind,
    input  logic [IDX_W-1:0]           idx,
    input  logic [WD_W-1:0]            word,
    input  logic [NSRC*PRIO_W-1:0]     prio_rd,
    input  logic [NWORDS*32-1:0]       pend_rd,
    input  logic [NCTX*NWORDS*32-1:0]  en_rd,
    input  logic [NCTX*PRIO_W-1:0]     thr_rd,
    input  logic [ID_W-1:0]            claim_id,
    output logic [31:0]                rd
);
    // Select by class; priority entries are stored from source 1 upward.
    always_comb begin
        int s, c, w;
        s  = int'(idx) - 1;
        c  = int'(idx);
        w  = int'(word);
        rd = '0;
        case (kind)
            RG_PRIO:  rd = 32'(prio_rd[s*PRIO_W +: PRIO_W]);
            RG_PEND:  rd = pend_rd[w*32 +: 32];
            RG_EN:    rd = en_rd[(c*NWORDS + w)*32 +: 32];
            RG_THR:   rd = 32'(thr_rd[c*PRIO_W +: PRIO_W]);
            RG_CLAIM: rd = 32'(claim_id);
            default:  rd = '0;
        endcase
    end
endmodule

// File: rtl/intc_reg_decoder.sv
// Register decoder for a platform interrupt controller core.
// Accepts one request when idle, strobes the core in that cycle, and
// acknowledges with data in the next. Strides must be powers of two.
module intc_reg_decoder
    import intc_dec_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          NSRC       = 40,
    parameter int          NCTX       = 2,
    parameter int          PRIO_W     = 3,
    parameter int          MAX_PRIO   = 5,
    parameter logic [31:0] PRIO_BASE  = 32'h0000,
    parameter logic [31:0] PEND_BASE  = 32'h1000,
    parameter logic [31:0] EN_BASE    = 32'h2000,
    parameter logic [31:0] EN_STRIDE  = 32'h0080,
    parameter logic [31:0] CTX_BASE   = 32'h4000,
    parameter logic [31:0] CTX_STRIDE = 32'h1000,
    localparam int ID_W   = $clog2(NSRC + 1),
    localparam int NWORDS = (NSRC + 1 + 31) / 32,
    localparam int CTX_W  = (NCTX > 1) ? $clog2(NCTX) : 1,
    localparam int WD_W   = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [31:0]                req_wdata,
    output logic                       req_ready,
    output logic [31:0]                resp_rdata,
    output logic                       resp_err,
    output logic                       prio_we,
    output logic                       en_we,
    output logic                       thr_we,
    output logic                       claim_stb,
    output logic                       cmpl_stb,
    output logic [ID_W-1:0]            core_src,
    output logic [CTX_W-1:0]           core_ctx,
    output logic [WD_W-1:0]            core_word,
    output logic [31:0]                core_wdata,
    output logic [PRIO_W-1:0]          prio_val,
    output logic [PRIO_W-1:0]          thr_val,
    input  logic [NSRC*PRIO_W-1:0]     prio_rd,
    input  logic [NWORDS*32-1:0]       pend_rd,
    input  logic [NCTX*NWORDS*32-1:0]  en_rd,
    input  logic [NCTX*PRIO_W-1:0]     thr_rd,
    input  logic [ID_W-1:0]            claim_id
);
    localparam int IDX_W = (ID_W > CTX_W) ? ID_W : CTX_W;

    rg_kind_t         kind;
    logic [IDX_W-1:0] idx;
    logic [31:0]      rd;
    logic             acc_err, fire, ack_q, err_q;
    logic [31:0]      rdata_q;

    // Accept only while no acknowledge is pending.
    assign fire = req_valid && !ack_q;

    intc_addr_decode #(
        .ADDR_W(ADDR_W), .NSRC(NSRC), .NCTX(NCTX),
        .PRIO_BASE(PRIO_BASE), .PEND_BASE(PEND_BASE),
        .EN_BASE(EN_BASE), .EN_STRIDE(EN_STRIDE),
        .CTX_BASE(CTX_BASE), .CTX_STRIDE(CTX_STRIDE),
        .IDX_W(IDX_W), .WD_W(WD_W)
    ) u_dec (
        .addr(req_addr), .kind(kind), .idx(idx), .word(core_word)
    );

    intc_strobe_gen #(
        .ID_W(ID_W), .CTX_W(CTX_W), .IDX_W(IDX_W),
        .PRIO_W(PRIO_W), .MAX_PRIO(MAX_PRIO)
    ) u_stb (
        .fire(fire), .write(req_write), .wdata(req_wdata),
        .kind(kind), .idx(idx), .acc_err(acc_err),
        .prio_we(prio_we), .en_we(en_we), .thr_we(thr_we),
        .claim_stb(claim_stb), .cmpl_stb(cmpl_stb),
        .core_src(core_src), .core_ctx(core_ctx),
        .prio_val(prio_val), .thr_val(thr_val)
    );

    intc_rdata_mux #(
        .NSRC(NSRC), .NCTX(NCTX), .NWORDS(NWORDS), .PRIO_W(PRIO_W),
        .ID_W(ID_W), .IDX_W(IDX_W), .WD_W(WD_W)
    ) u_mux (
        .kind(kind), .idx(idx), .word(core_word),
        .prio_rd(prio_rd), .pend_rd(pend_rd), .en_rd(en_rd),
        .thr_rd(thr_rd), .claim_id(claim_id), .rd(rd)
    );

    // Acknowledge state and registered response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q   <= 1'b0;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else if (ack_q) begin
            ack_q <= 1'b0;
        end else if (req_valid) begin
            ack_q   <= 1'b1;
            err_q   <= acc_err;
            rdata_q <= (req_write || acc_err) ? 32'd0 : rd;
        end
    end

    assign req_ready  = ack_q;
    assign resp_rdata = rdata_q;
    assign resp_err   = err_q;
    assign core_wdata = req_wdata;
endmodule

// File: rtl/intc_reg_decoder_chk.sv
// Property checker for the register decoder, bound to every instance.
module intc_reg_decoder_chk #(
    parameter int PRIO_W   = 3,
    parameter int MAX_PRIO = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic              req_ready,
    input logic              resp_err,
    input logic [31:0]       resp_rdata,
    input logic              prio_we,
    input logic              en_we,
    input logic              thr_we,
    input logic              claim_stb,
    input logic              cmpl_stb,
    input logic [PRIO_W-1:0] thr_val
);
    a_r1_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);
    a_r1_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> req_ready);
    a_r10_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && resp_err) |-> (resp_rdata == 32'd0));
    a_r6_thr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        thr_we |-> (32'(thr_val) <= 32'(MAX_PRIO)));
    a_r7_claim_read: assert property (@(posedge clk) disable iff (!rst_n)
        claim_stb |-> (req_valid && !req_write && !req_ready));
    a_r11_claim_once: assert property (@(posedge clk) disable iff (!rst_n)
        claim_stb |=> !claim_stb);
    a_r12_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prio_we, en_we, thr_we, claim_stb, cmpl_stb}));
endmodule

bind intc_reg_decoder intc_reg_decoder_chk #(
    .PRIO_W(PRIO_W), .MAX_PRIO(MAX_PRIO)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_ready(req_ready), .resp_err(resp_err), .resp_rdata(resp_rdata),
    .prio_we(prio_we), .en_we(en_we), .thr_we(thr_we),
    .claim_stb(claim_stb), .cmpl_stb(cmpl_stb), .thr_val(thr_val)
);

// File: tb/tb_intc_reg_decoder.sv
// Scoreboard bench: the driver queues expected responses and strobes,
// a monitor compares them against each acknowledge.
module tb_intc_reg_decoder;
    localparam int NSRC = 40, NCTX = 2, PRIO_W = 3, NWORDS = 2, ID_W = 6;

    // Strobe kinds observed by the monitor.
    localparam int K_NONE = 0, K_PRIO = 1, K_EN = 2, K_THR = 3, K_CLM = 4, K_CMP = 5;

    typedef struct {
        logic [31:0] rdata;
        logic        err;
        int          kind;
        int          a;
        int          b;
        logic [31:0] d;
        string       tag;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic req_ready, resp_err, prio_we, en_we, thr_we, claim_stb, cmpl_stb;
    logic [31:0] resp_rdata, core_wdata;
    logic [ID_W-1:0] core_src;
    logic [0:0] core_ctx, core_word;
    logic [PRIO_W-1:0] prio_val, thr_val;
    logic [NSRC*PRIO_W-1:0] prio_rd;
    logic [NWORDS*32-1:0] pend_rd = 64'h8000_0021_F0F0_1E02;
    logic [NCTX*NWORDS*32-1:0] en_rd = {32'hE000_0101, 32'hE000_0100,
                                        32'hE000_0001, 32'hE000_0000};
    logic [NCTX*PRIO_W-1:0] thr_rd = {3'd6, 3'd2};
    logic [ID_W-1:0] claim_id = 6'd37;

    int checks = 0, errors = 0;
    exp_t q[$];
    int nstb = 0, okind = 0, oa = 0, ob = 0;
    logic [31:0] od = '0;

    always #4 clk = ~clk;

    intc_reg_decoder dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .resp_rdata(resp_rdata), .resp_err(resp_err), .prio_we(prio_we),
        .en_we(en_we), .thr_we(thr_we), .claim_stb(claim_stb), .cmpl_stb(cmpl_stb),
        .core_src(core_src), .core_ctx(core_ctx), .core_word(core_word),
        .core_wdata(core_wdata), .prio_val(prio_val), .thr_val(thr_val),
        .prio_rd(prio_rd), .pend_rd(pend_rd), .en_rd(en_rd), .thr_rd(thr_rd),
        .claim_id(claim_id)
    );

    // Priority table: source s holds s mod 8.
    initial begin
        for (int i = 0; i < NSRC; i++) prio_rd[i*PRIO_W +: PRIO_W] = 3'((i + 1) & 7);
    end

    // Monitor: collect strobes, compare at each acknowledge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prio_we)   begin nstb++; okind = K_PRIO; oa = int'(core_src); ob = 0; od = 32'(prio_val); end
            if (en_we)     begin nstb++; okind = K_EN;   oa = int'(core_ctx); ob = int'(core_word); od = core_wdata; end
            if (thr_we)    begin nstb++; okind = K_THR;  oa = int'(core_ctx); ob = 0; od = 32'(thr_val); end
            if (claim_stb) begin nstb++; okind = K_CLM;  oa = int'(core_ctx); ob = 0; od = 0; end
            if (cmpl_stb)  begin nstb++; okind = K_CMP;  oa = int'(core_ctx); ob = 0; od = 32'(core_src); end
            if (req_ready) begin
                exp_t e;
                checks++;
                if (q.size() == 0) begin
                    errors++;
                    $display("FAIL R1: unexpected acknowledge, actual ready=1 expected ready=0");
                end else begin
                    e = q.pop_front();
                    if (resp_rdata !== e.rdata || resp_err !== e.err ||
                        nstb != ((e.kind == K_NONE) ? 0 : 1) || okind != e.kind ||
                        (e.kind != K_NONE && (oa != e.a || ob != e.b || od !== e.d))) begin
                        errors++;
                        $display("FAIL %s: actual rdata=%h err=%b strobes=%0d kind=%0d a=%0d b=%0d d=%h expected rdata=%h err=%b kind=%0d a=%0d b=%0d d=%h",
                                 e.tag, resp_rdata, resp_err, nstb, okind, oa, ob, od,
                                 e.rdata, e.err, e.kind, e.a, e.b, e.d);
                    end
                end
                nstb = 0; okind = K_NONE; oa = 0; ob = 0; od = '0;
            end
        end
    end

    // Driver: queue expectation, present request, wait for acknowledge.
    task automatic xfer(input bit wr, input logic [15:0] ad, input logic [31:0] wd,
                        input logic [31:0] er, input bit ee, input int k,
                        input int ea, input int eb, input logic [31:0] ed, input string tag);
        exp_t e;
        e.rdata = er; e.err = ee; e.kind = k; e.a = ea; e.b = eb; e.d = ed; e.tag = tag;
        q.push_back(e);
        req_valid = 1'b1; req_write = wr; req_addr = ad; req_wdata = wd;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #2;
    endtask

    task automatic idle();
        req_valid = 1'b0;
        @(posedge clk); #2;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (req_ready !== 1'b0 || resp_err !== 1'b0 || resp_rdata !== 32'd0) begin
            errors++;
            $display("FAIL R1 reset: actual ready=%b err=%b rdata=%h expected 0 0 0",
                     req_ready, resp_err, resp_rdata);
        end
        @(posedge clk); #2;
        // R3 priority window, offset by one source
        xfer(0, 16'h000C, 0, 32'd4, 0, K_NONE, 0, 0, 0, "R3 read src4");
        xfer(0, 16'h0098, 0, 32'd7, 0, K_NONE, 0, 0, 0, "R3 read src39");
        xfer(1, 16'h0010, 32'hFFFF_FFFD, 0, 0, K_PRIO, 5, 0, 32'd5, "R3 write src5");
        idle();
        // R4 pending window
        xfer(0, 16'h1004, 0, 32'h8000_0021, 0, K_NONE, 0, 0, 0, "R4 read word1");
        xfer(0, 16'h1000, 0, 32'hF0F0_1E02, 0, K_NONE, 0, 0, 0, "R4 read word0");
        xfer(1, 16'h1000, 32'hFFFF_FFFF, 0, 1, K_NONE, 0, 0, 0, "R4 write rejected");
        // R5 enable window
        xfer(0, 16'h2084, 0, 32'hE000_0101, 0, K_NONE, 0, 0, 0, "R5 read ctx1 w1");
        xfer(1, 16'h2004, 32'h1234_5678, 0, 0, K_EN, 0, 1, 32'h1234_5678, "R5 write ctx0 w1");
        xfer(1, 16'h2088, 32'h1, 0, 1, K_NONE, 0, 0, 0, "R5 write word beyond");
        xfer(0, 16'h2008, 0, 0, 1, K_NONE, 0, 0, 0, "R5 read word beyond");
        idle();
        // R6 threshold
        xfer(0, 16'h5000, 0, 32'd6, 0, K_NONE, 0, 0, 0, "R6 read ctx1");
        xfer(1, 16'h4000, 32'd5, 0, 0, K_THR, 0, 0, 32'd5, "R6 write max");
        xfer(1, 16'h4000, 32'd6, 0, 0, K_NONE, 0, 0, 0, "R6 drop above max");
        xfer(1, 16'h5000, 32'hFFFF_0001, 0, 0, K_NONE, 0, 0, 0, "R6 drop high bits");
        // R7 claim, R8 complete
        xfer(0, 16'h5004, 0, 32'd37, 0, K_CLM, 1, 0, 0, "R7 claim ctx1");
        xfer(1, 16'h4004, 32'hFFFF_FFE5, 0, 0, K_CMP, 0, 0, 32'd37, "R8 complete ctx0");
        idle();
        // R9 bad context offsets
        xfer(0, 16'h4008, 0, 0, 1, K_NONE, 0, 0, 0, "R9 read offset 8");
        xfer(1, 16'h5010, 32'd1, 0, 1, K_NONE, 0, 0, 0, "R9 write offset 16");
        // R10 outside all windows
        xfer(0, 16'h00A0, 0, 0, 1, K_NONE, 0, 0, 0, "R10 past priority");
        xfer(0, 16'h6000, 0, 0, 1, K_NONE, 0, 0, 0, "R10 past contexts");
        xfer(1, 16'h3000, 32'd3, 0, 1, K_NONE, 0, 0, 0, "R10 write gap");
        xfer(0, 16'h2100, 0, 0, 1, K_NONE, 0, 0, 0, "R10 past enables");
        idle();
        // R2 misaligned
        xfer(0, 16'h0006, 0, 0, 1, K_NONE, 0, 0, 0, "R2 misaligned read");
        xfer(1, 16'h0011, 32'd3, 0, 1, K_NONE, 0, 0, 0, "R2 misaligned write");
        // R11 back-to-back claims with valid held
        xfer(0, 16'h4004, 0, 32'd37, 0, K_CLM, 0, 0, 0, "R11 claim first");
        xfer(0, 16'h4004, 0, 32'd37, 0, K_CLM, 0, 0, 0, "R11 claim second");
        // R12 claim then priority write, each with one strobe
        xfer(1, 16'h009C, 32'd2, 0, 0, K_PRIO, 40, 0, 32'd2, "R12 write src40");
        idle();
        repeat (3) @(posedge clk);
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R1: actual pending=%0d expected pending=0", q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule